// File: doc/BRIEF.md
# Multi-Length PRBS Stimulus Generator

This block produces a serial test stream for exercising a device under test with data whose run lengths vary. The stream comes from a linear feedback shift register whose length can be set to 7, 10, 11, 15 or 23 stages. It can also be switched to a plain alternating pattern, or to a gated burst that emits a counted number of pseudorandom bits and then stops. A seed, a length and a mode are captured together by a single load pulse. From that load onward the generator runs on those settings until the next load.

The bits leave on a valid/ready stream with one bit per transfer. `out_valid` is a pure function of the generator state and never waits on `out_ready`. A transfer happens on each clock edge where both are high, and only a transfer advances the sequence. While `out_ready` is low, `out_bit` and `out_valid` are held, so the sink can apply back-pressure for any number of cycles and lose nothing. Load and start are plain control pulses and do not handshake.

Top module: `prbs_stim_gen`

## Requirements
- R1: After reset, `out_valid` stays 0 until the first `load` pulse. From the edge that captures a load, `out_valid` is 1 in the continuous and alternating modes.
- R2: With `len_sel`=4 the register has 23 stages. Stage 1 takes the XOR of stages 18 and 23, and `out_bit` is stage 23. The first bit after a load is bit 22 of the captured seed, and each transfer shifts stage k into stage k+1.
- R3: `len_sel` codes 0, 1, 2 and 3 select 7, 10, 11 and 15 stages, with the feedback taken from stages 6, 7, 9 and 14 respectively, XORed with the last stage. The output is the last stage. Codes 5 to 7 act as code 4.
- R4: If the seed bits inside the selected length are all zero, the register is loaded with all ones in that length instead, so the register can never hold zero.
- R5: Every length is maximal. With 7 stages the output repeats with period 127 and carries 64 ones per period.
- R6: Seed bits above the selected length are discarded and have no effect on the sequence.
- R7: While `out_valid`=1 and `out_ready`=0, `out_bit` and `out_valid` hold, and the sequence advances only on a transfer.
- R8: `mode_sel`=1 gives an alternating stream that starts with 1 after the load and inverts on every transfer.
- R9: `mode_sel`=2 is burst mode. After a load `out_valid` is 0. A `start` pulse arms a count of `burst_len`, and exactly that many PRBS bits are transferred before `out_valid` falls. A later `start` re-arms the count and continues the same sequence.
- R10: In burst mode a `start` with `burst_len`=0 produces no valid bits.
- R11: Changes on `len_sel` and `mode_sel` have no effect until the next `load`. `mode_sel`=3 is treated as 0 (continuous PRBS).
- R12: A `load` in the middle of a run restarts the output from the new seed on the next bit. When both pulses arrive in the same cycle, `load` wins over `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures seed, length and mode |
| seed | input | MAX_W | Seed value, masked to the selected length |
| len_sel | input | 3 | Register length code |
| mode_sel | input | 2 | 0 PRBS, 1 alternating, 2 burst |
| start | input | 1 | Arms a burst of `burst_len` bits |
| burst_len | input | BURST_W | Burst bit count |
| out_ready | input | 1 | Sink accepts a bit |
| out_valid | output | 1 | A bit is offered |
| out_bit | output | 1 | Serial data bit |

## Verification
The bench builds the block with its defaults: a 23-bit register and a 16-bit burst counter. With those values every length code can be reached, including the full 23-stage polynomial, whose first 64 bits are compared against a model in the bench. The 127-bit period of the 7-stage length is short enough to observe twice and compare end to end. The back-pressure and burst corners are covered with small burst counts and a randomly gated ready signal.

// File: rtl/prbs_stim_pkg.sv
package prbs_stim_pkg;

  typedef enum logic [1:0] {
    MODE_PRBS  = 2'd0,
    MODE_ALT   = 2'd1,
    MODE_BURST = 2'd2,
    MODE_RSVD  = 2'd3
  } stim_mode_e;

  localparam int NUM_LEN = 5;
  localparam int LEN_TAB [NUM_LEN] = '{7, 10, 11, 15, 23};
  localparam int TAP_TAB [NUM_LEN] = '{6, 7, 9, 14, 18};
  localparam int LEN_IDX_W = 3;
  localparam int MAX_SUPPORTED = 23;

  function automatic logic [63:0] len_mask(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [LEN_IDX_W-1:0] norm_len(input logic [LEN_IDX_W-1:0] code);
    return (code > LEN_IDX_W'(NUM_LEN - 1)) ? LEN_IDX_W'(NUM_LEN - 1) : code;
  endfunction

  function automatic stim_mode_e norm_mode(input logic [1:0] code);
    return (code == 2'd3) ? MODE_PRBS : stim_mode_e'(code);
  endfunction

endpackage

// File: rtl/prbs_len_mask.sv
module prbs_len_mask
  import prbs_stim_pkg::*;
#(
  parameter int MAX_W = 23
) (
  input  logic [LEN_IDX_W-1:0] len_idx,
  output logic [MAX_W-1:0]     mask
);
  logic [MAX_W-1:0] mask_v [NUM_LEN];

  for (genvar g = 0; g < NUM_LEN; g++) begin : g_mask
    logic [63:0] full;
    assign full      = len_mask(LEN_TAB[g]);
    assign mask_v[g] = full[MAX_W-1:0];
  end

  always_comb begin
    mask = mask_v[NUM_LEN-1];
    for (int i = 0; i < NUM_LEN; i++) begin
      if (len_idx == LEN_IDX_W'(i)) mask = mask_v[i];
    end
  end
endmodule

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard #(
  parameter int MAX_W = 23
) (
  input  logic [MAX_W-1:0] seed,
  input  logic [MAX_W-1:0] mask,
  output logic [MAX_W-1:0] seed_ok
);
  logic [MAX_W-1:0] kept;

  always_comb begin
    kept    = seed & mask;
    seed_ok = (kept == '0) ? mask : kept;
  end
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
  import prbs_stim_pkg::*;
#(
  parameter int MAX_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [MAX_W-1:0]     load_val,
  input  logic                 step,
  input  logic [LEN_IDX_W-1:0] len_idx,
  input  logic [MAX_W-1:0]     mask,
  output logic [MAX_W-1:0]     state,
  output logic                 msb
);
  logic [MAX_W-1:0] state_q;
  logic [NUM_LEN-1:0] fb_v;
  logic [NUM_LEN-1:0] last_v;
  logic fb;

  for (genvar g = 0; g < NUM_LEN; g++) begin : g_poly
    assign last_v[g] = state_q[LEN_TAB[g]-1];
    assign fb_v[g]   = state_q[LEN_TAB[g]-1] ^ state_q[TAP_TAB[g]-1];
  end

  always_comb begin
    fb  = fb_v[NUM_LEN-1];
    msb = last_v[NUM_LEN-1];
    for (int i = 0; i < NUM_LEN; i++) begin
      if (len_idx == LEN_IDX_W'(i)) begin
        fb  = fb_v[i];
        msb = last_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '1;
    end else if (load) begin
      state_q <= load_val;
    end else if (step) begin
      state_q <= {state_q[MAX_W-2:0], fb} & mask;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/prbs_burst_ctr.sv
module prbs_burst_ctr #(
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               arm,
  input  logic [BURST_W-1:0] count_in,
  input  logic               dec,
  output logic [BURST_W-1:0] remaining,
  output logic               live
);
  logic [BURST_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= count_in;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - BURST_W'(1);
    end
  end

  assign remaining = cnt_q;
  assign live      = (cnt_q != '0);
endmodule

// File: rtl/prbs_stim_gen.sv
module prbs_stim_gen
  import prbs_stim_pkg::*;
#(
  parameter int MAX_W   = 23,
  parameter int BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [MAX_W-1:0]   seed,
  input  logic [2:0]         len_sel,
  input  logic [1:0]         mode_sel,
  input  logic               start,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_bit
);
  logic [LEN_IDX_W-1:0] new_len;
  logic [LEN_IDX_W-1:0] cfg_len_q;
  stim_mode_e           cfg_mode_q;
  logic                 armed_q;
  logic                 alt_q;
  logic [MAX_W-1:0]     new_mask;
  logic [MAX_W-1:0]     cfg_mask;
  logic [MAX_W-1:0]     seed_ok;
  logic [MAX_W-1:0]     lfsr_state;
  logic                 lfsr_bit;
  logic [BURST_W-1:0]   burst_left;
  logic                 burst_live;
  logic                 fire;
  logic                 is_alt;
  logic                 is_burst;

  assign new_len  = norm_len(len_sel);
  assign is_alt   = (cfg_mode_q == MODE_ALT);
  assign is_burst = (cfg_mode_q == MODE_BURST);

  prbs_len_mask #(.MAX_W(MAX_W)) u_mask_new (
    .len_idx (new_len),
    .mask    (new_mask)
  );

  prbs_len_mask #(.MAX_W(MAX_W)) u_mask_cfg (
    .len_idx (cfg_len_q),
    .mask    (cfg_mask)
  );

  prbs_seed_guard #(.MAX_W(MAX_W)) u_guard (
    .seed    (seed),
    .mask    (new_mask),
    .seed_ok (seed_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_len_q  <= LEN_IDX_W'(NUM_LEN - 1);
      cfg_mode_q <= MODE_PRBS;
      armed_q    <= 1'b0;
      alt_q      <= 1'b1;
    end else if (load) begin
      cfg_len_q  <= new_len;
      cfg_mode_q <= norm_mode(mode_sel);
      armed_q    <= 1'b1;
      alt_q      <= 1'b1;
    end else if (fire && is_alt) begin
      alt_q      <= ~alt_q;
    end
  end

  assign out_valid = armed_q && (!is_burst || burst_live);
  assign out_bit   = is_alt ? alt_q : lfsr_bit;
  assign fire      = out_valid && out_ready;

  prbs_lfsr #(.MAX_W(MAX_W)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (seed_ok),
    .step     (fire && !is_alt),
    .len_idx  (cfg_len_q),
    .mask     (cfg_mask),
    .state    (lfsr_state),
    .msb      (lfsr_bit)
  );

  prbs_burst_ctr #(.BURST_W(BURST_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (load),
    .arm       (start),
    .count_in  (burst_len),
    .dec       (fire && is_burst),
    .remaining (burst_left),
    .live      (burst_live)
  );
endmodule

// File: rtl/prbs_stim_checker.sv
module prbs_stim_checker #(
  parameter int MAX_W   = 23,
  parameter int BURST_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load,
  input logic               start,
  input logic               out_ready,
  input logic               out_valid,
  input logic               out_bit,
  input logic               armed,
  input logic [1:0]         mode,
  input logic [2:0]         cfg_len,
  input logic [MAX_W-1:0]   state,
  input logic [MAX_W-1:0]   mask,
  input logic [BURST_W-1:0] burst_left
);
  logic hs;
  assign hs = out_valid && out_ready;

  // R1
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_valid);

  // R4
  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R6
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state & ~mask) == '0);

  // R7
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load && !start) |=> (out_valid && $stable(out_bit)));

  // R8
  a_r8_alt_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && hs && !load) |=> (out_bit != $past(out_bit)));

  // R9
  a_r9_burst_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && hs && burst_left == BURST_W'(1) && !load && !start) |=> !out_valid);

  // R11
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cfg_len) && $stable(mode)));
endmodule

bind prbs_stim_gen prbs_stim_checker #(.MAX_W(MAX_W), .BURST_W(BURST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .start      (start),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .out_bit    (out_bit),
  .armed      (armed_q),
  .mode       (cfg_mode_q),
  .cfg_len    (cfg_len_q),
  .state      (lfsr_state),
  .mask       (cfg_mask),
  .burst_left (burst_left)
);

// File: tb/prbs_stim_gen_bench.sv
`timescale 1ns/1ps
module prbs_stim_gen_bench;
  localparam int W  = 23;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] seed = '0;
  logic [2:0] len_sel = 3'd4;
  logic [1:0] mode_sel = 2'd0;
  logic start = 1'b0;
  logic [BW-1:0] burst_len = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_bit;

  always #2 clk = ~clk;

  prbs_stim_gen #(.MAX_W(W), .BURST_W(BW)) u_prbs_stim_gen (
    .clk, .rst_n, .load, .seed, .len_sel, .mode_sel, .start, .burst_len,
    .out_ready, .out_valid, .out_bit
  );

  int vec = 0;
  int bad = 0;
  logic exp_q [$];
  string tag_q [$];
  logic got [$];
  logic force_rdy = 1'b0;

  logic [W-1:0] ref_s;
  int ref_n;
  int ref_t;

  function automatic int len_of(input int code);
    case (code)
      0: return 7; 1: return 10; 2: return 11; 3: return 15; default: return 23;
    endcase
  endfunction
  function automatic int tap_of(input int n);
    case (n)
      7: return 6; 10: return 7; 11: return 9; 15: return 14; default: return 18;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops an expected bit for every transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      got.push_back(out_bit);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected transfer", out_bit, -1);
      end else begin
        automatic logic e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(out_bit == e, t, out_bit, e);
      end
    end
  end

  // ready: randomly gated while bits are expected (R7 back-pressure)
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = force_rdy || ((exp_q.size() > 0) && ($urandom % 4 != 0));
    end
  end

  task automatic do_load(input logic [W-1:0] s, input int code, input int mode);
    @(posedge clk); #1;
    load = 1'b1; seed = s; len_sel = 3'(code); mode_sel = 2'(mode);
    @(posedge clk); #1;
    load = 1'b0;
    ref_n = len_of(code);
    ref_t = tap_of(ref_n);
    ref_s = s & W'((64'd1 << ref_n) - 1);
    if (ref_s == '0) ref_s = W'((64'd1 << ref_n) - 1);
  endtask

  task automatic push_prbs(input int k, input string t);
    for (int i = 0; i < k; i++) begin
      automatic logic fb = ref_s[ref_n-1] ^ ref_s[ref_t-1];
      exp_q.push_back(ref_s[ref_n-1]);
      tag_q.push_back(t);
      ref_s = {ref_s[W-2:0], fb} & W'((64'd1 << ref_n) - 1);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  task automatic pulse_start(input int n);
    @(posedge clk); #1;
    start = 1'b1; burst_len = BW'(n);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 no load yet", out_valid, 0);

    // R2: 23-stage, first 64 bits
    do_load(23'h5A3C91, 4, 0);
    check(out_valid == 1'b1, "R1 valid after load", out_valid, 1);
    check(out_bit == 1'b1, "R2 first bit is seed bit 22", out_bit, 1);
    // R7: bit holds while ready is low
    repeat (3) @(posedge clk);
    #1;
    check(out_bit == 1'b1 && out_valid, "R7 hold under stall", out_bit, 1);
    push_prbs(64, "R2 prbs23 bit");
    drain();

    // R5: 7-stage period
    do_load(23'h000001, 0, 0);
    got.delete();
    push_prbs(254, "R5 prbs7 bit");
    drain();
    begin
      automatic int ones = 0;
      automatic int mism = 0;
      for (int i = 0; i < 127; i++) begin
        ones += got[i];
        if (got[i] != got[i+127]) mism++;
      end
      check(mism == 0, "R5 period 127", mism, 0);
      check(ones == 64, "R5 ones per period", ones, 64);
    end

    // R3: other lengths, and code 6 acting as 23
    do_load(23'h0002B7, 1, 0); push_prbs(40, "R3 len10"); drain();
    do_load(23'h0004D1, 2, 0); push_prbs(40, "R3 len11"); drain();
    do_load(23'h00730F, 3, 0); push_prbs(40, "R3 len15"); drain();
    do_load(23'h123456, 6, 0); push_prbs(40, "R3 code6 as len23"); drain();

    // R4: zero seed and masked-zero seed
    do_load(23'h000000, 0, 0); push_prbs(20, "R4 zero seed"); drain();
    do_load(23'h7FFF80, 0, 0); push_prbs(20, "R4 masked zero"); drain();

    // R6: upper seed bits discarded
    do_load(23'h7FFF81, 0, 0); push_prbs(30, "R6 upper bits ignored"); drain();

    // R8: alternating
    do_load(23'h000011, 0, 1);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(logic'(i % 2 == 0)); tag_q.push_back("R8 alt bit");
    end
    drain();

    // R9: burst
    do_load(23'h000001, 0, 2);
    check(out_valid == 1'b0, "R9 burst idle after load", out_valid, 0);
    push_prbs(5, "R9 burst bit");
    pulse_start(5);
    drain();
    force_rdy = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R9 burst stopped", out_valid, 0);
    force_rdy = 1'b0;
    push_prbs(3, "R9 burst restart");
    pulse_start(3);
    drain();
    force_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R9 second burst stopped", out_valid, 0);

    // R10: zero burst length
    pulse_start(0);
    repeat (4) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10 zero burst", out_valid, 0);
    force_rdy = 1'b0;

    // R11: config pins ignored without load; mode 3 acts as PRBS
    do_load(23'h000005, 0, 3);
    push_prbs(10, "R11 mode3 as prbs");
    drain();
    @(posedge clk); #1;
    len_sel = 3'd4; mode_sel = 2'd1;
    push_prbs(10, "R11 pins ignored");
    drain();

    // R12: reload mid-run, load beats start
    do_load(23'h00003C, 0, 0);
    push_prbs(5, "R12 pre reload");
    drain();
    @(posedge clk); #1;
    load = 1'b1; start = 1'b1; burst_len = BW'(9);
    seed = 23'h000321; len_sel = 3'd2; mode_sel = 2'd2;
    @(posedge clk); #1;
    load = 1'b0; start = 1'b0;
    check(out_valid == 1'b0, "R12 load wins over start", out_valid, 0);
    do_load(23'h000321, 2, 0);
    push_prbs(12, "R12 reload restart");
    drain();

    repeat (3) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule